// File: doc/BRIEF.md
# Fault-Aware Slice Distribution Unit

This block sits on the sending side of a data path that is split into four 16-bit slices. A storage register upstream assembles a 64-bit word quarter by quarter and reports which quarters are present. The unit takes that word and places it on the downstream slices. It uses only the slices that a downstream health mask marks as usable. When fewer than four slices survive, the word is sent as a short series of fragments over consecutive cycles, which is time-division multiplexing over the remaining lanes.

There are two sending styles. In whole-word style the unit waits until every quarter is present and then drains the word without pausing. This style is required whenever the consumer must see a complete word, for example a head flit that feeds route computation. In streaming style each fragment leaves as soon as its own quarters have arrived. After the last fragment of a word the unit raises a one-cycle strobe, so the upstream assembler can clear its presence mask and start the next word. The style select and the health mask are captured into registers only while the unit is idle.

Top module: `slice_dist_unit`

## Requirements
- R1: While reset is high and in the first cycle after it, `lane_data_o`, `lane_vld_o` and `store_free_o` are all zero.
- R2: Bit L of `slice_ok_i` set to 1 means downstream slice L is usable. The number of lanes used per fragment is the largest power of two not above the count of usable slices: four usable gives 4, three or two give 2, one gives 1. The lanes used are the lowest-indexed usable ones, and `lane_vld_o` marks exactly those lanes in each cycle a fragment is sent.
- R3: Every 16-bit lane whose `lane_vld_o` bit is 0 drives zero. This includes every lane marked unusable.
- R4: Quarter q of the word is bits 16q+15:16q. Quarters leave in ascending order. Within a fragment, the used lane of rank r (counted from the lowest index) carries quarter p+r, where p is the first quarter of that fragment.
- R5: A word takes 4/W fragments on consecutive sending cycles, where W is the width from R2. With all four lanes usable it takes one cycle; with two usable it takes two.
- R6: In whole-word style (`pipe_mode_i`=0) no fragment of a word is sent until all four bits of `store_qv_i` are 1. From then on the fragments follow on back-to-back cycles until the word is drained.
- R7: In streaming style (`pipe_mode_i`=1) a fragment is sent as soon as the presence bits of all its quarters are 1, without waiting for the rest of the word.
- R8: `store_free_o` is high for exactly the one cycle in which the last fragment of a word is on the lanes. After that cycle no fragment is sent until `store_qv_i` has been seen at all-zero.
- R9: `pipe_mode_i` and `slice_ok_i` are captured only in idle cycles where nothing is sent, and take effect from the next cycle. Changing them in the middle of a word has no effect on that word.
- R10: When no slice is usable, nothing is sent and `store_free_o` stays low, whatever `store_qv_i` shows.
- R11: Every output is registered. A send decision made at one clock edge is visible on the lanes right after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pipe_mode_i | input | 1 | 1 = streaming style, 0 = whole-word style; captured when idle |
| slice_ok_i | input | 4 | Downstream slice health mask, 1 = usable; captured when idle |
| store_word_i | input | 64 | Contents of the upstream storage register |
| store_qv_i | input | 4 | Quarter presence mask of the storage register, bit q for quarter q |
| lane_data_o | output | 64 | Downstream slice lanes, lane L on bits 16L+15:16L |
| lane_vld_o | output | 4 | Per-lane valid mask for the current fragment |
| store_free_o | output | 1 | Last fragment of the word is on the lanes this cycle |

## Verification
If the fragment pointer is wrong, the quarter order or the pairing of lanes and quarters breaks. That shows on the lane data in the very cycle the bad fragment goes out, and a skipped or repeated quarter also moves the free strobe one fragment early or late. If the sequencer leaves its drain-wait state too early, the same word is sent a second time one cycle after the strobe. If the captured configuration is stale or taken mid-word, the valid mask changes width or lane set within a word, which is visible in the next sending cycle. The bench runs a cycle-accurate model of these rules and compares every lane, the valid mask and the strobe on every cycle, under directed corner cases and random health masks, styles and fill timing.

// File: rtl/sdu_pkg.sv
package sdu_pkg;

  // Sequencer phases: waiting for a word, part-way through one,
  // and holding off after the last fragment until the store empties.
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_BUSY = 2'd1,
    ST_WAIT = 2'd2
  } seq_state_e;

endpackage

// File: rtl/sdu_width_decode.sv
// Maps a slice health mask to the per-fragment width (power of two)
// and to the rank of each lane that takes part in a fragment.
module sdu_width_decode #(
  parameter int N_SLICES = 4,
  localparam int PW = $clog2(N_SLICES),
  localparam int STW = PW + 1
) (
  input  logic [N_SLICES-1:0]    ok_i,
  output logic [N_SLICES-1:0]    use_o,
  output logic [N_SLICES*PW-1:0] rank_o,
  output logic [STW-1:0]         step_o
);

  int cnt;
  int width;
  int rank;

  always_comb begin
    cnt = 0;
    for (int l = 0; l < N_SLICES; l++) begin
      cnt = cnt + int'(ok_i[l]);
    end

    // R2: largest power of two that does not exceed the usable count
    width = 0;
    for (int p = 1; p <= N_SLICES; p = p * 2) begin
      if (p <= cnt) width = p;
    end

    use_o  = '0;
    rank_o = '0;
    rank   = 0;
    for (int l = 0; l < N_SLICES; l++) begin
      if (ok_i[l]) begin
        if (rank < width) begin
          use_o[l]            = 1'b1;
          rank_o[l*PW +: PW]  = PW'(rank);
        end
        rank = rank + 1;
      end
    end

    step_o = STW'(width);
  end

endmodule

// File: rtl/sdu_sequencer.sv
// Decides, cycle by cycle, whether the next fragment may go out,
// tracks the quarter pointer and holds the captured configuration.
module sdu_sequencer
  import sdu_pkg::*;
#(
  parameter int N_SLICES = 4,
  localparam int PW = $clog2(N_SLICES),
  localparam int STW = PW + 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                pipe_mode_i,
  input  logic [N_SLICES-1:0] ok_i,
  input  logic [N_SLICES-1:0] qv_i,
  input  logic [STW-1:0]      step_i,
  output logic [N_SLICES-1:0] cfg_ok_o,
  output logic                cfg_pipe_o,
  output logic                send_o,
  output logic                last_o,
  output logic [PW-1:0]       ptr_o
);

  localparam logic [STW-1:0] FULL_CNT = STW'(N_SLICES);

  seq_state_e          st_q, st_d;
  logic [PW-1:0]       ptr_q, ptr_d;
  logic [STW-1:0]      nxt;
  logic [N_SLICES-1:0] need;
  logic                have;
  logic                load;

  always_comb begin
    nxt = {1'b0, ptr_q} + step_i;

    // Quarters covered by the fragment that starts at ptr_q
    for (int q = 0; q < N_SLICES; q++) begin
      need[q] = (q >= int'(ptr_q)) && (q < int'(nxt));
    end
    have = ((qv_i & need) == need);

    send_o = 1'b0;
    if (st_q != ST_WAIT && step_i != '0) begin
      if (cfg_pipe_o) begin
        send_o = have;                  // R7: stream what is present
      end else if (st_q == ST_IDLE) begin
        send_o = &qv_i;                 // R6: start only on a full word
      end else begin
        send_o = 1'b1;                  // R6: drain without gaps
      end
    end

    last_o = send_o && (nxt == FULL_CNT);
    load   = (st_q == ST_IDLE) && !send_o;   // R9: capture only when idle

    st_d  = st_q;
    ptr_d = ptr_q;
    if (send_o) begin
      if (last_o) begin
        st_d  = ST_WAIT;
        ptr_d = '0;
      end else begin
        st_d  = ST_BUSY;
        ptr_d = nxt[PW-1:0];
      end
    end else if (st_q == ST_WAIT && qv_i == '0) begin
      st_d = ST_IDLE;                   // R8: store seen empty
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q       <= ST_IDLE;
      ptr_q      <= '0;
      cfg_ok_o   <= '0;
      cfg_pipe_o <= 1'b0;
    end else begin
      st_q  <= st_d;
      ptr_q <= ptr_d;
      if (load) begin
        cfg_ok_o   <= ok_i;
        cfg_pipe_o <= pipe_mode_i;
      end
    end
  end

  assign ptr_o = ptr_q;

endmodule

// File: rtl/sdu_lane_drive.sv
// Output register stage: one registered lane per slice, fed by a
// quarter select, plus the registered free strobe.
module sdu_lane_drive #(
  parameter int N_SLICES = 4,
  parameter int SLICE_W  = 16,
  localparam int PW = $clog2(N_SLICES),
  localparam int DW = N_SLICES * SLICE_W
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   send_i,
  input  logic                   last_i,
  input  logic [PW-1:0]          ptr_i,
  input  logic [N_SLICES-1:0]    use_i,
  input  logic [N_SLICES*PW-1:0] rank_i,
  input  logic [DW-1:0]          word_i,
  output logic [DW-1:0]          lane_o,
  output logic [N_SLICES-1:0]    vld_o,
  output logic                   free_o
);

  for (genvar l = 0; l < N_SLICES; l++) begin : g_lane
    logic [PW-1:0]      qidx;
    logic [SLICE_W-1:0] lane_q;
    logic               vld_q;

    assign qidx = ptr_i + rank_i[l*PW +: PW];

    always_ff @(posedge clk) begin
      if (rst) begin
        lane_q <= '0;
        vld_q  <= 1'b0;
      end else begin
        vld_q  <= send_i & use_i[l];
        lane_q <= (send_i & use_i[l]) ? word_i[qidx*SLICE_W +: SLICE_W] : '0;
      end
    end

    assign lane_o[l*SLICE_W +: SLICE_W] = lane_q;
    assign vld_o[l]                     = vld_q;
  end

  always_ff @(posedge clk) begin
    if (rst) free_o <= 1'b0;
    else     free_o <= last_i;
  end

endmodule

// File: rtl/slice_dist_unit.sv
module slice_dist_unit #(
  parameter int N_SLICES = 4,
  parameter int SLICE_W  = 16,
  localparam int PW  = $clog2(N_SLICES),
  localparam int STW = PW + 1,
  localparam int DW  = N_SLICES * SLICE_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                pipe_mode_i,
  input  logic [N_SLICES-1:0] slice_ok_i,
  input  logic [DW-1:0]       store_word_i,
  input  logic [N_SLICES-1:0] store_qv_i,
  output logic [DW-1:0]       lane_data_o,
  output logic [N_SLICES-1:0] lane_vld_o,
  output logic                store_free_o
);

  logic [N_SLICES-1:0]    cfg_ok;
  logic                   cfg_pipe;
  logic [N_SLICES-1:0]    use_mask;
  logic [N_SLICES*PW-1:0] rank;
  logic [STW-1:0]         step;
  logic                   send;
  logic                   last;
  logic [PW-1:0]          ptr;

  sdu_width_decode #(.N_SLICES(N_SLICES)) dec_i (
    .ok_i   (cfg_ok),
    .use_o  (use_mask),
    .rank_o (rank),
    .step_o (step)
  );

  sdu_sequencer #(.N_SLICES(N_SLICES)) seq_i (
    .clk         (clk),
    .rst         (rst),
    .pipe_mode_i (pipe_mode_i),
    .ok_i        (slice_ok_i),
    .qv_i        (store_qv_i),
    .step_i      (step),
    .cfg_ok_o    (cfg_ok),
    .cfg_pipe_o  (cfg_pipe),
    .send_o      (send),
    .last_o      (last),
    .ptr_o       (ptr)
  );

  sdu_lane_drive #(.N_SLICES(N_SLICES), .SLICE_W(SLICE_W)) drv_i (
    .clk    (clk),
    .rst    (rst),
    .send_i (send),
    .last_i (last),
    .ptr_i  (ptr),
    .use_i  (use_mask),
    .rank_i (rank),
    .word_i (store_word_i),
    .lane_o (lane_data_o),
    .vld_o  (lane_vld_o),
    .free_o (store_free_o)
  );

endmodule

// File: rtl/slice_dist_unit_chk.sv
module slice_dist_unit_chk #(
  parameter int N_SLICES = 4,
  parameter int SLICE_W  = 16,
  localparam int PW = $clog2(N_SLICES),
  localparam int DW = N_SLICES * SLICE_W
) (
  input logic                clk,
  input logic                rst,
  input logic [DW-1:0]       lane_data_o,
  input logic [N_SLICES-1:0] lane_vld_o,
  input logic                store_free_o,
  input logic [N_SLICES-1:0] store_qv_i,
  input logic [N_SLICES-1:0] cfg_ok,
  input logic                cfg_pipe,
  input logic [PW-1:0]       ptr
);

  // R3: a valid lane is always one the captured mask calls usable
  assert_vld_in_ok_R3: assert property (@(posedge clk) disable iff (rst)
    (lane_vld_o & ~$past(cfg_ok)) == '0);

  // R3: lanes without a valid bit carry zero
  for (genvar l = 0; l < N_SLICES; l++) begin : g_zero
    assert_idle_lane_zero_R3: assert property (@(posedge clk) disable iff (rst)
      !lane_vld_o[l] |-> lane_data_o[l*SLICE_W +: SLICE_W] == '0);
  end

  // R2: fragment width is a power of two
  assert_width_pow2_R2: assert property (@(posedge clk) disable iff (rst)
    ($countones(lane_vld_o) & ($countones(lane_vld_o) - 1)) == 0);

  // R8: the free strobe comes with a fragment
  assert_free_has_data_R8: assert property (@(posedge clk) disable iff (rst)
    store_free_o |-> lane_vld_o != '0);

  // R8: nothing follows the last fragment in the next cycle
  assert_gap_after_free_R8: assert property (@(posedge clk) disable iff (rst)
    store_free_o |=> lane_vld_o == '0);

  // R6: a word starts in whole-word style only from a full store
  assert_whole_word_start_R6: assert property (@(posedge clk) disable iff (rst)
    (lane_vld_o != '0 && !$past(cfg_pipe) && $past(ptr) == '0)
      |-> $past(&store_qv_i));

endmodule

bind slice_dist_unit slice_dist_unit_chk #(
  .N_SLICES(N_SLICES),
  .SLICE_W (SLICE_W)
) chk_i (
  .clk          (clk),
  .rst          (rst),
  .lane_data_o  (lane_data_o),
  .lane_vld_o   (lane_vld_o),
  .store_free_o (store_free_o),
  .store_qv_i   (store_qv_i),
  .cfg_ok       (cfg_ok),
  .cfg_pipe     (cfg_pipe),
  .ptr          (ptr)
);

// File: tb/slice_dist_unit_tb_top.sv
`timescale 1ns/1ps
module slice_dist_unit_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        pipe_mode = 1'b0;
  logic [3:0]  ok = 4'hF;
  logic [63:0] word = '0;
  logic [3:0]  qv = '0;
  logic [63:0] lane_data;
  logic [3:0]  lane_vld;
  logic        store_free;

  int total = 0;
  int bad   = 0;

  // reference model state
  int         m_ptr  = 0;
  bit         m_wait = 1'b0;
  bit         m_pipe = 1'b0;
  logic [3:0] m_ok   = 4'h0;
  logic [63:0] e_lane;
  logic [3:0]  e_vld;
  bit          e_free;

  slice_dist_unit dut_i (
    .clk          (clk),
    .rst          (rst),
    .pipe_mode_i  (pipe_mode),
    .slice_ok_i   (ok),
    .store_word_i (word),
    .store_qv_i   (qv),
    .lane_data_o  (lane_data),
    .lane_vld_o   (lane_vld),
    .store_free_o (store_free)
  );

  always #10 clk = ~clk;

  function automatic int width_of(input logic [3:0] g);
    int c;
    c = $countones(g);
    if (c >= 4) return 4;
    if (c >= 2) return 2;
    return c;
  endfunction

  function automatic logic [63:0] expand(input logic [3:0] v);
    logic [63:0] m;
    for (int l = 0; l < 4; l++) m[l*16 +: 16] = {16{v[l]}};
    return m;
  endfunction

  task automatic check(input bit cond, input string tag,
                       input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!cond) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic model_predict();
    int k;
    int r;
    bit snd;
    bit load;
    k   = width_of(m_ok);
    snd = 1'b0;
    if (!m_wait && k > 0) begin
      if (m_pipe) begin
        snd = 1'b1;
        for (int q = m_ptr; q < m_ptr + k; q++) if (!qv[q]) snd = 1'b0;
      end else begin
        snd = (m_ptr != 0) || (qv == 4'hF);
      end
    end
    e_lane = '0;
    e_vld  = '0;
    r      = 0;
    if (snd) begin
      for (int l = 0; l < 4; l++) begin
        if (m_ok[l] && r < k) begin
          e_vld[l]          = 1'b1;
          e_lane[l*16 +: 16] = word[(m_ptr + r)*16 +: 16];
          r++;
        end
      end
    end
    e_free = snd && (m_ptr + k == 4);
    load   = !m_wait && (m_ptr == 0) && !snd;
    if (snd) begin
      if (e_free) begin
        m_ptr  = 0;
        m_wait = 1'b1;
      end else begin
        m_ptr = m_ptr + k;
      end
    end else if (m_wait && qv == 4'h0) begin
      m_wait = 1'b0;
    end
    if (load) begin
      m_pipe = pipe_mode;
      m_ok   = ok;
    end
  endtask

  // One clock: predict, let the edge pass, compare after the edge (R11)
  task automatic step();
    logic [63:0] m;
    model_predict();
    @(posedge clk);
    @(negedge clk);
    m = expand(e_vld);
    check(lane_vld === e_vld, "R2 valid mask", 64'(lane_vld), 64'(e_vld));
    check((lane_data & m) === e_lane, "R4 fragment data", lane_data & m, e_lane);
    check((lane_data & ~m) === 64'h0, "R3 unused lanes zero", lane_data & ~m, 64'h0);
    check(store_free === e_free, "R8 free strobe", 64'(store_free), 64'(e_free));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired act=hung exp=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int frags;
    void'($urandom(32'h0051_1CE5));

    // R1: reset state
    repeat (3) @(negedge clk);
    check(lane_data === 64'h0, "R1 reset lanes", lane_data, 64'h0);
    check(lane_vld === 4'h0, "R1 reset valid", 64'(lane_vld), 64'h0);
    check(store_free === 1'b0, "R1 reset free", 64'(store_free), 64'h0);
    rst = 1'b0;

    // R5: all four usable, whole word in one fragment
    ok = 4'hF; pipe_mode = 1'b0; qv = 4'h0;
    step(); step();
    word = 64'h4444_3333_2222_1111; qv = 4'hF;
    step();
    check(lane_vld === 4'hF && store_free, "R5 one fragment at full width",
          {lane_vld, 3'b0, store_free}, {4'hF, 3'b0, 1'b1});
    check(lane_data === word, "R4 full word order", lane_data, word);
    qv = 4'h0; step();

    // R5: two usable lanes (0 and 2), two fragments
    ok = 4'b0101; step(); step();
    word = 64'hDDDD_CCCC_BBBB_AAAA; qv = 4'hF;
    step();
    check(lane_vld === 4'b0101 && !store_free, "R5 first of two fragments",
          {lane_vld, 3'b0, store_free}, {4'b0101, 4'b0});
    check(lane_data === 64'h0000_BBBB_0000_AAAA, "R4 lanes 0,2 carry q0,q1",
          lane_data, 64'h0000_BBBB_0000_AAAA);
    step();
    check(lane_vld === 4'b0101 && store_free, "R5 second fragment ends word",
          {lane_vld, 3'b0, store_free}, {4'b0101, 4'b1});
    check(lane_data === 64'h0000_DDDD_0000_CCCC, "R3 faulty lanes 1,3 zero",
          lane_data, 64'h0000_DDDD_0000_CCCC);
    qv = 4'h0; step();

    // R6: whole-word style holds a partial word
    ok = 4'b1000; step(); step();
    word = 64'h0D0D_0C0C_0B0B_0A0A; qv = 4'b0111;
    for (int i = 0; i < 4; i++) begin
      step();
      check(lane_vld === 4'h0, "R6 partial word held", 64'(lane_vld), 64'h0);
    end
    qv = 4'hF;
    frags = 0;
    for (int i = 0; i < 4; i++) begin
      step();
      if (lane_vld != 4'h0) frags++;
      check(lane_data[63:48] === word[i*16 +: 16], "R4 single lane quarter order",
            64'(lane_data[63:48]), 64'(word[i*16 +: 16]));
    end
    check(frags == 4 && store_free, "R6 back-to-back drain of four fragments",
          64'(frags), 64'd4);
    qv = 4'h0; step();

    // R7: streaming style over lanes 1 and 2
    pipe_mode = 1'b1; ok = 4'b0110; step(); step();
    word = 64'h7777_6666_5555_4444; qv = 4'b0001;
    step();
    check(lane_vld === 4'h0, "R7 half a fragment is not sent", 64'(lane_vld), 64'h0);
    qv = 4'b0011; step();
    check(lane_vld === 4'b0110 && lane_data === 64'h0000_5555_4444_0000,
          "R7 early fragment forwarded", lane_data, 64'h0000_5555_4444_0000);
    qv = 4'b0111; step();
    check(lane_vld === 4'h0, "R7 waits for quarter 3", 64'(lane_vld), 64'h0);
    qv = 4'hF; step();
    check(lane_vld === 4'b0110 && store_free, "R7 final fragment with free",
          {lane_vld, 3'b0, store_free}, {4'b0110, 4'b1});
    qv = 4'h0; step();

    // R9: configuration change mid-word is ignored
    pipe_mode = 1'b0; ok = 4'b0010; step(); step();
    word = 64'h9004_9003_9002_9001; qv = 4'hF;
    step();
    ok = 4'hF; pipe_mode = 1'b1;
    for (int i = 1; i < 4; i++) begin
      step();
      check(lane_vld === 4'b0010 && lane_data[31:16] === word[i*16 +: 16],
            "R9 word keeps its captured width", 64'(lane_vld), 64'(4'b0010));
    end
    qv = 4'h0; step(); step();
    word = 64'h1234_5678_9ABC_DEF0; qv = 4'hF;
    step();
    check(lane_vld === 4'hF && store_free, "R9 new setting used for next word",
          {lane_vld, 3'b0, store_free}, {4'hF, 4'b1});
    qv = 4'h0; step();

    // R10: no usable slice, nothing leaves
    pipe_mode = 1'b0; ok = 4'h0; step(); step();
    word = 64'hFEED_FACE_CAFE_BEEF; qv = 4'hF;
    for (int i = 0; i < 5; i++) begin
      step();
      check(lane_vld === 4'h0 && !store_free, "R10 no lanes, no send",
            {lane_vld, 3'b0, store_free}, 64'h0);
    end
    ok = 4'hF; step(); step();
    check(lane_vld === 4'hF && lane_data === word, "R10 resumes once lanes return",
          lane_data, word);
    qv = 4'h0; step();

    // Random phase: masks, styles and fill timing
    word = {$urandom, $urandom};
    for (int i = 0; i < 3000; i++) begin
      if ($urandom % 20 == 0) ok = 4'($urandom);
      if ($urandom % 40 == 0) pipe_mode = 1'($urandom);
      step();
      if (store_free) begin
        qv   = 4'h0;
        word = {$urandom, $urandom};
      end else if (qv != 4'hF && ($urandom % 3) != 0) begin
        qv = {qv[2:0], 1'b1};
      end
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule